// File: doc/BRIEF.md
# Threshold-Filtered Result Queue with Watermark

This block holds the measurement results that a scan sequencer produces until software collects them. Each result arrives with its measured value, the number of the descriptor that produced it, and the threshold programmed for that descriptor. A mode bit selects what is kept. In one setting every valid result is queued. In the other, a result is queued only when its value is strictly greater than the threshold that came with it.

Software drains the queue through a show-ahead read port and can see the current fill count. The count is compared against a 10-bit watermark level to produce a status flag. The same condition drives an interrupt that passes two gates: a local queue-interrupt enable and a global enable. The global enable also gates the descriptor-completion interrupt request, which enters from outside and leaves through the same gate.

A result that arrives while the queue is full is lost and sets a sticky overflow flag. That flag stays set until software clears it. The watermark register that feeds this block resets to 512 and is held outside the block.

Top module: `result_store`

## Requirements
- R1: With `store_above` = 0, every cycle with `res_valid` = 1 queues the result `{res_tag, res_value}` when the queue is not full, whatever the threshold.
- R2: With `store_above` = 1, a valid result is queued only when `res_value` > `res_thresh` as unsigned numbers. A result equal to or below its threshold is discarded and has no effect on count or contents.
- R3: `rd_data` shows the oldest queued entry as `{tag[3:0], value[15:0]}`, and `rd_empty` is 1 exactly when nothing is queued. A `rd_pop` removes that entry. A `rd_pop` while empty changes nothing.
- R4: `fill_count` is the number of queued entries (0 to 1024). A push and a pop in the same cycle leave it unchanged.
- R5: `wm_flag` is 1 exactly when `fill_count` >= `wm_level`.
- R6: `fifo_irq` is 1 exactly when `glob_ie`, `fifo_ie` and `wm_flag` are all 1.
- R7: `desc_irq` is 1 exactly when `glob_ie` and `desc_req` are both 1.
- R8: A result that would be queued while the count is 1024 is dropped, even when a pop happens in the same cycle, and `ovf_flag` is set from the next cycle.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr` = 1 and no drop. When a drop and a clear fall in the same cycle, the flag stays set.
- R10: During and right after reset the queue is empty, the count is 0 and `ovf_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | A result is offered this cycle |
| res_value | input | 16 | Measured value |
| res_thresh | input | 16 | Threshold of the producing descriptor |
| res_tag | input | 4 | Descriptor number |
| store_above | input | 1 | 1: keep only results above threshold |
| rd_pop | input | 1 | Remove the oldest entry |
| rd_data | output | 20 | Oldest entry, tag over value |
| rd_empty | output | 1 | Queue holds no entry |
| fill_count | output | 11 | Number of entries held |
| wm_level | input | 10 | Watermark level |
| fifo_ie | input | 1 | Queue interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| desc_req | input | 1 | Descriptor-completion interrupt request |
| ovf_clr | input | 1 | Clear the overflow flag |
| wm_flag | output | 1 | Fill count has reached the watermark |
| fifo_irq | output | 1 | Gated watermark interrupt |
| desc_irq | output | 1 | Gated descriptor interrupt |
| ovf_flag | output | 1 | Sticky overflow status |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a push and a pop. The bench provokes it on a partly filled queue, where the count must hold and the order must be kept. It also provokes it on a full queue, where the pop must succeed, the push must be dropped and the count must fall to 1023. The second pair is an overflow drop and a software clear. The bench raises both in one cycle and expects the flag to stay set, then clears it alone and expects it to fall. A queue model in the bench is compared against every output at every clock.

// File: rtl/result_store_pkg.sv
package result_store_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_move_e;

  // A result is kept when filtering is off, or when its value is strictly above the threshold.
  function automatic logic keep_result(input logic above_only,
                                       input logic [31:0] value,
                                       input logic [31:0] thresh);
    return !above_only || (value > thresh);
  endfunction

  // The watermark is reached when the count is at or above the level.
  function automatic logic level_met(input logic [31:0] count,
                                     input logic [31:0] level);
    return count >= level;
  endfunction

  // Advance a ring index, wrapping at the depth.
  function automatic logic [31:0] ring_next(input logic [31:0] idx,
                                            input logic [31:0] depth);
    return (idx == depth - 1) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic cnt_move_e count_move(input logic push, input logic pop);
    if (push && !pop) return CNT_UP;
    if (pop && !push) return CNT_DOWN;
    return CNT_HOLD;
  endfunction

endpackage

// File: rtl/rs_filter.sv
module rs_filter
  import result_store_pkg::*;
#(
  parameter int VW = 16
) (
  input  logic          valid_i,
  input  logic          above_only_i,
  input  logic [VW-1:0] value_i,
  input  logic [VW-1:0] thresh_i,
  input  logic          full_i,
  output logic          push_o,
  output logic          drop_o
);

  logic wanted;

  always_comb begin
    wanted = valid_i && keep_result(above_only_i, 32'(value_i), 32'(thresh_i));
    push_o = wanted && !full_i;
    drop_o = wanted && full_i;
  end

endmodule

// File: rtl/rs_ring.sv
module rs_ring
  import result_store_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 20,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_req_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          pop_acc_o
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [DW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wr_idx_q, rd_idx_q, wr_idx_nx, rd_idx_nx;
  logic [CW-1:0] count_q;
  cnt_move_e     move;

  generate
    if (POW2) begin : g_natural_wrap
      always_comb begin
        wr_idx_nx = wr_idx_q + AW'(1);
        rd_idx_nx = rd_idx_q + AW'(1);
      end
    end else begin : g_compare_wrap
      always_comb begin
        wr_idx_nx = AW'(ring_next(32'(wr_idx_q), 32'(DEPTH)));
        rd_idx_nx = AW'(ring_next(32'(rd_idx_q), 32'(DEPTH)));
      end
    end
  endgenerate

  always_comb begin
    empty_o   = (count_q == '0);
    full_o    = (count_q == CW'(DEPTH));
    pop_acc_o = pop_req_i && !empty_o;
    move      = count_move(push_i, pop_acc_o);
    rdata_o   = slot_q[rd_idx_q];
    count_o   = count_q;
  end

  always_ff @(posedge clk) begin
    if (push_i) slot_q[wr_idx_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i)    wr_idx_q <= wr_idx_nx;
      if (pop_acc_o) rd_idx_q <= rd_idx_nx;
      unique case (move)
        CNT_UP:   count_q <= count_q + CW'(1);
        CNT_DOWN: count_q <= count_q - CW'(1);
        default:  count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/rs_flags.sv
module rs_flags
  import result_store_pkg::*;
#(
  parameter int CW = 11,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count_i,
  input  logic [LW-1:0] level_i,
  input  logic          fifo_ie_i,
  input  logic          glob_ie_i,
  input  logic          desc_req_i,
  input  logic          drop_i,
  input  logic          ovf_clr_i,
  output logic          wm_o,
  output logic          fifo_irq_o,
  output logic          desc_irq_o,
  output logic          ovf_o
);

  logic ovf_q;

  always_comb begin
    wm_o       = level_met(32'(count_i), 32'(level_i));
    fifo_irq_o = glob_ie_i && fifo_ie_i && wm_o;
    desc_irq_o = glob_ie_i && desc_req_i;
    ovf_o      = ovf_q;
  end

  // A drop outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (drop_i)    ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

endmodule

// File: rtl/result_store.sv
module result_store
  import result_store_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int VW    = 16,
  parameter int TW    = 4,
  parameter int LW    = 10,
  localparam int DW   = TW + VW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid,
  input  logic [VW-1:0] res_value,
  input  logic [VW-1:0] res_thresh,
  input  logic [TW-1:0] res_tag,
  input  logic          store_above,
  input  logic          rd_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_empty,
  output logic [CW-1:0] fill_count,
  input  logic [LW-1:0] wm_level,
  input  logic          fifo_ie,
  input  logic          glob_ie,
  input  logic          desc_req,
  input  logic          ovf_clr,
  output logic          wm_flag,
  output logic          fifo_irq,
  output logic          desc_irq,
  output logic          ovf_flag
);

  // Internal events, named for the checker.
  logic push_acc;
  logic drop_ev;
  logic pop_acc;
  logic ring_full;

  rs_filter #(.VW(VW)) u_filter (
    .valid_i      (res_valid),
    .above_only_i (store_above),
    .value_i      (res_value),
    .thresh_i     (res_thresh),
    .full_i       (ring_full),
    .push_o       (push_acc),
    .drop_o       (drop_ev)
  );

  rs_ring #(.DEPTH(DEPTH), .DW(DW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_acc),
    .pop_req_i (rd_pop),
    .wdata_i   ({res_tag, res_value}),
    .rdata_o   (rd_data),
    .count_o   (fill_count),
    .empty_o   (rd_empty),
    .full_o    (ring_full),
    .pop_acc_o (pop_acc)
  );

  rs_flags #(.CW(CW), .LW(LW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (fill_count),
    .level_i    (wm_level),
    .fifo_ie_i  (fifo_ie),
    .glob_ie_i  (glob_ie),
    .desc_req_i (desc_req),
    .drop_i     (drop_ev),
    .ovf_clr_i  (ovf_clr),
    .wm_o       (wm_flag),
    .fifo_irq_o (fifo_irq),
    .desc_irq_o (desc_irq),
    .ovf_o      (ovf_flag)
  );

endmodule

// File: rtl/result_store_chk.sv
module result_store_chk #(
  parameter int DEPTH = 1024,
  parameter int VW    = 16,
  parameter int CW    = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          store_above,
  input logic [VW-1:0] res_value,
  input logic [VW-1:0] res_thresh,
  input logic          push_acc,
  input logic          drop_ev,
  input logic          pop_acc,
  input logic          rd_pop,
  input logic          rd_empty,
  input logic [CW-1:0] fill_count,
  input logic          glob_ie,
  input logic          fifo_irq,
  input logic          desc_irq,
  input logic          ovf_clr,
  input logic          ovf_flag
);

  assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && store_above) |-> (res_value > res_thresh));

  assert_pop_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_empty && !push_acc) |=> $stable(fill_count));

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count <= CW'(DEPTH));

  assert_count_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop_acc) |=> $stable(fill_count));

  assert_count_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && !pop_acc) |=> (fill_count == $past(fill_count) + CW'(1)));

  assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> (!fifo_irq && !desc_irq));

  assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |-> (fill_count == CW'(DEPTH) && !push_acc));

  assert_ovf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_ev |=> ovf_flag);

  assert_ovf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind result_store result_store_chk #(.DEPTH(DEPTH), .VW(VW), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .store_above (store_above),
  .res_value   (res_value),
  .res_thresh  (res_thresh),
  .push_acc    (push_acc),
  .drop_ev     (drop_ev),
  .pop_acc     (pop_acc),
  .rd_pop      (rd_pop),
  .rd_empty    (rd_empty),
  .fill_count  (fill_count),
  .glob_ie     (glob_ie),
  .fifo_irq    (fifo_irq),
  .desc_irq    (desc_irq),
  .ovf_clr     (ovf_clr),
  .ovf_flag    (ovf_flag)
);

// File: tb/sim_result_store.sv
module sim_result_store;

  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_valid;
  logic [15:0] res_value, res_thresh;
  logic [3:0]  res_tag;
  logic        store_above, rd_pop;
  logic [19:0] rd_data;
  logic        rd_empty;
  logic [10:0] fill_count;
  logic [9:0]  wm_level;
  logic        fifo_ie, glob_ie, desc_req, ovf_clr;
  logic        wm_flag, fifo_irq, desc_irq, ovf_flag;

  always #4 clk = ~clk;

  result_store u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_value(res_value),
    .res_thresh(res_thresh), .res_tag(res_tag), .store_above(store_above),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_empty(rd_empty),
    .fill_count(fill_count), .wm_level(wm_level), .fifo_ie(fifo_ie),
    .glob_ie(glob_ie), .desc_req(desc_req), .ovf_clr(ovf_clr),
    .wm_flag(wm_flag), .fifo_irq(fifo_irq), .desc_irq(desc_irq),
    .ovf_flag(ovf_flag)
  );

  int          n_chk = 0;
  int          n_bad = 0;
  logic [19:0] mq[$];
  bit          m_ovf = 0;
  int          tag_ctr = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit wm_exp;
    wm_exp = mq.size() >= int'(wm_level);
    chk("R4", "fill_count", 32'(fill_count), 32'(mq.size()));
    chk("R3", "rd_empty", 32'(rd_empty), 32'(mq.size() == 0));
    if (mq.size() > 0) chk("R3", "rd_data", 32'(rd_data), 32'(mq[0]));
    chk("R5", "wm_flag", 32'(wm_flag), 32'(wm_exp));
    chk("R6", "fifo_irq", 32'(fifo_irq), 32'(glob_ie && fifo_ie && wm_exp));
    chk("R7", "desc_irq", 32'(desc_irq), 32'(glob_ie && desc_req));
    chk("R9", "ovf_flag", 32'(ovf_flag), 32'(m_ovf));
  endtask

  // Apply one cycle of stimulus at the falling edge, model the rising edge, compare at the next falling edge.
  task automatic step(input bit v, input int val, input int thr, input bit pop, input bit clr);
    bit keep, full;
    res_valid  = v;
    res_value  = 16'(val);
    res_thresh = 16'(thr);
    res_tag    = 4'(tag_ctr);
    rd_pop     = pop;
    ovf_clr    = clr;
    keep = !store_above || (16'(val) > 16'(thr));
    full = mq.size() == DEPTH;
    @(posedge clk);
    if (pop && mq.size() > 0) void'(mq.pop_front());
    if (v && keep) begin
      if (!full) mq.push_back({4'(tag_ctr), 16'(val)});
      else m_ovf = 1;
    end else if (clr) m_ovf = 0;
    if (v && keep && full && clr) m_ovf = 1;
    @(negedge clk);
    tag_ctr++;
    compare_all();
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; res_valid = 0; res_value = 0; res_thresh = 0; res_tag = 0;
    store_above = 0; rd_pop = 0; wm_level = 10'd512; fifo_ie = 0;
    glob_ie = 0; desc_req = 0; ovf_clr = 0;
    repeat (3) @(negedge clk);
    chk("R10", "count in reset", 32'(fill_count), 0);
    chk("R10", "empty in reset", 32'(rd_empty), 1);
    chk("R10", "ovf in reset", 32'(ovf_flag), 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0);
    chk("R10", "count after reset", 32'(fill_count), 0);

    // R1: unfiltered, thresholds ignored; watermark crossing at 4.
    wm_level = 10'd4; fifo_ie = 1; glob_ie = 1;
    step(1, 5, 100, 0, 0);
    step(1, 100, 100, 0, 0);
    step(1, 0, 65535, 0, 0);
    step(0, 77, 0, 0, 0);
    step(1, 65535, 1, 0, 0);
    step(1, 300, 299, 0, 0);
    chk("R1", "six-minus-idle stored", 32'(fill_count), 5);

    // R3: drain in order, then pop on empty.
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 0);
    chk("R3", "empty after extra pops", 32'(rd_empty), 1);

    // R2: filtering around the threshold.
    store_above = 1;
    step(1, 99, 100, 0, 0);
    step(1, 100, 100, 0, 0);
    step(1, 101, 100, 0, 0);
    step(1, 0, 0, 0, 0);
    step(1, 65535, 65535, 0, 0);
    step(1, 65535, 65534, 0, 0);
    step(1, 1, 0, 0, 0);
    chk("R2", "above-threshold only", 32'(fill_count), 3);

    // R4: simultaneous push and pop keeps the count.
    store_above = 0;
    for (int i = 0; i < 5; i++) step(1, 1000 + i, 0, 1, 0);
    chk("R4", "count held under push+pop", 32'(fill_count), 3);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);

    // R6 and R7: gating combinations.
    wm_level = 10'd0;
    for (int k = 0; k < 8; k++) begin
      glob_ie = k[0]; fifo_ie = k[1]; desc_req = k[2];
      step(0, 0, 0, 0, 0);
    end
    glob_ie = 1; fifo_ie = 1; desc_req = 0;

    // R8, R9: fill to full with the watermark near the top.
    wm_level = 10'd1023;
    for (int i = 0; i < DEPTH; i++) step(1, i, 0, 0, 0);
    chk("R4", "count at full", 32'(fill_count), 1024);
    step(1, 4242, 0, 0, 0);
    chk("R8", "drop sets ovf", 32'(ovf_flag), 1);
    step(1, 4343, 0, 1, 0);
    chk("R8", "push with pop at full dropped", 32'(fill_count), 1023);
    step(0, 0, 0, 0, 0);
    chk("R9", "ovf sticky", 32'(ovf_flag), 1);
    step(0, 0, 0, 0, 1);
    chk("R9", "ovf cleared", 32'(ovf_flag), 0);
    step(1, 17, 0, 0, 0);
    step(1, 18, 0, 0, 1);
    chk("R9", "drop beats clear", 32'(ovf_flag), 1);
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0);
    chk("R3", "drained", 32'(rd_empty), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule